// File: doc/BRIEF.md
# Mailbox Interrupt Flags

This block generates the two port-to-port interrupt flags of a two-port shared memory. The top two addresses of the array act as mailboxes: the all-ones address belongs to the right port, and the address one below it belongs to the left port. When one port writes into the other port's mailbox, the owner's interrupt is raised. When the owner reads its own mailbox with select and output enable active, its interrupt drops. The message bytes themselves live in the ordinary array, outside this block.

Each port presents its address, select, write and output-enable strobes each clock cycle, together with a busy indication from the arbitration logic. A busy port can neither raise the other side's flag nor clear its own. The interrupt outputs are active low and registered, so each result appears one clock after the access that causes it.

Top module: `mbx_irq_flags`

## Requirements
- R1: The address width AW is a parameter. The right port's mailbox is the all-ones address and the left port's mailbox is all-ones minus one.
- R2: A left-port cycle with select high, write high and busy low, addressed to the all-ones address, drives rt_irq_n low on the following cycle.
- R3: A right-port cycle with select high, write high and busy low, addressed to all-ones minus one, drives lt_irq_n low on the following cycle.
- R4: A port that reads its own mailbox (select high, write low, output enable high, busy low) returns its own interrupt output to high on the following cycle, unless a set of that same flag occurs in the same cycle.
- R5: A read of the own mailbox with output enable low leaves the interrupt unchanged.
- R6: Reading the other port's mailbox changes neither interrupt output.
- R7: A write into the other port's mailbox while the writer's busy is high does not raise the other port's interrupt.
- R8: A read of the own mailbox while that port's busy is high does not clear its interrupt.
- R9: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (output low).
- R10: While reset is asserted, and after it is released, both interrupt outputs are high until a set occurs.
- R11: A write with select low, a write to an address outside the two mailboxes, or a write by a port into its own mailbox changes neither interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| lt_addr | input | AW | Left port address |
| lt_sel | input | 1 | Left port select, active high |
| lt_wr | input | 1 | Left port write (1) or read (0) |
| lt_oe | input | 1 | Left port output enable, active high |
| lt_busy | input | 1 | Left port busy from arbitration, active high |
| rt_addr | input | AW | Right port address |
| rt_sel | input | 1 | Right port select, active high |
| rt_wr | input | 1 | Right port write (1) or read (0) |
| rt_oe | input | 1 | Right port output enable, active high |
| rt_busy | input | 1 | Right port busy from arbitration, active high |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
A set or a clear takes effect on the interrupt output one cycle after the access: the clock edge that samples the strobes also loads the output register. The bench therefore applies each access on a falling edge, returns the strobes to idle on the next falling edge, and samples both outputs at that moment, just after the loading edge. The internal reset release adds two cycles, and the bench waits those out before its first access. Outcomes that must show no change are observed in the same slot, after a flag has been set in a known way beforehand.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_LT   = 0;
  localparam int unsigned PORT_RT   = 1;

  // Requests that one port's access produces in a cycle
  typedef struct packed {
    logic set_peer;  // write into the peer's mailbox
    logic clr_own;   // qualified read of the own mailbox
  } mbx_evt_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter bit          OWN_TOP = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          sel,
  input  logic          wr,
  input  logic          oe,
  input  logic          busy,
  output mbx_evt_t      evt
);
  localparam logic [AW-1:0] MB_TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] MB_NEXT = MB_TOP - {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] own_mb;
  logic [AW-1:0] peer_mb;

  generate
    if (OWN_TOP) begin : g_own_top
      assign own_mb  = MB_TOP;
      assign peer_mb = MB_NEXT;
    end else begin : g_own_next
      assign own_mb  = MB_NEXT;
      assign peer_mb = MB_TOP;
    end
  endgenerate

  logic hit_own;
  logic hit_peer;
  logic active;

  always_comb begin
    hit_own      = (addr == own_mb);
    hit_peer     = (addr == peer_mb);
    active       = sel && !busy;
    evt.set_peer = active && wr && hit_peer;
    evt.clr_own  = active && !wr && oe && hit_own;
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  logic irq_n_q;
  logic irq_n_d;
  logic upd_en;

  // set has priority over clear
  always_comb begin
    upd_en  = set_req || clr_req;
    irq_n_d = !set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else if (upd_en) begin
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
  import mbx_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lt_addr,
  input  logic          lt_sel,
  input  logic          lt_wr,
  input  logic          lt_oe,
  input  logic          lt_busy,
  input  logic [AW-1:0] rt_addr,
  input  logic          rt_sel,
  input  logic          rt_wr,
  input  logic          rt_oe,
  input  logic          rt_busy,
  output logic          lt_irq_n,
  output logic          rt_irq_n
);
  logic rst_sync_n;

  mbx_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk      (clk),
    .rst_in_n (rst_n),
    .rst_out_n(rst_sync_n)
  );

  logic [AW-1:0] p_addr [NUM_PORTS];
  logic [NUM_PORTS-1:0] p_sel, p_wr, p_oe, p_busy, p_irq_n;
  mbx_evt_t p_evt [NUM_PORTS];

  assign p_addr[PORT_LT] = lt_addr;
  assign p_addr[PORT_RT] = rt_addr;
  assign p_sel  = {rt_sel,  lt_sel};
  assign p_wr   = {rt_wr,   lt_wr};
  assign p_oe   = {rt_oe,   lt_oe};
  assign p_busy = {rt_busy, lt_busy};

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      mbx_port_decode #(
        .AW     (AW),
        .OWN_TOP(p == PORT_RT)
      ) dec_i (
        .addr(p_addr[p]),
        .sel (p_sel[p]),
        .wr  (p_wr[p]),
        .oe  (p_oe[p]),
        .busy(p_busy[p]),
        .evt (p_evt[p])
      );

      mbx_irq_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .set_req(p_evt[NUM_PORTS-1-p].set_peer),
        .clr_req(p_evt[p].clr_own),
        .irq_n  (p_irq_n[p])
      );
    end
  endgenerate

  assign lt_irq_n = p_irq_n[PORT_LT];
  assign rt_irq_n = p_irq_n[PORT_RT];
endmodule

// File: rtl/mbx_irq_flags_chk.sv
module mbx_irq_flags_chk #(
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [AW-1:0] lt_addr,
  input logic          lt_sel,
  input logic          lt_wr,
  input logic          lt_oe,
  input logic          lt_busy,
  input logic [AW-1:0] rt_addr,
  input logic          rt_sel,
  input logic          rt_wr,
  input logic          rt_oe,
  input logic          rt_busy,
  input logic          lt_irq_n,
  input logic          rt_irq_n
);
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - {{(AW-1){1'b0}}, 1'b1};

  logic lt_sets, rt_sets, lt_clears, rt_clears;
  assign lt_sets   = lt_sel && lt_wr && (lt_addr == TOP)  && !lt_busy;
  assign rt_sets   = rt_sel && rt_wr && (rt_addr == NEXT) && !rt_busy;
  assign lt_clears = lt_sel && !lt_wr && lt_oe && (lt_addr == NEXT) && !lt_busy;
  assign rt_clears = rt_sel && !rt_wr && rt_oe && (rt_addr == TOP)  && !rt_busy;

  assert_set_rt_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lt_sets |=> !rt_irq_n);

  assert_set_lt_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rt_sets |=> !lt_irq_n);

  assert_clr_rt_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rt_clears && !lt_sets) |=> rt_irq_n);

  assert_clr_lt_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lt_clears && !rt_sets) |=> lt_irq_n);

  assert_fall_rt_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(rt_irq_n) |-> $past(lt_sets));

  assert_fall_lt_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(lt_irq_n) |-> $past(rt_sets));

  assert_rise_rt_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rt_irq_n) |-> $past(rt_clears && !lt_sets));

  assert_rise_lt_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(lt_irq_n) |-> $past(lt_clears && !rt_sets));
endmodule

bind mbx_irq_flags mbx_irq_flags_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .lt_addr   (lt_addr),
  .lt_sel    (lt_sel),
  .lt_wr     (lt_wr),
  .lt_oe     (lt_oe),
  .lt_busy   (lt_busy),
  .rt_addr   (rt_addr),
  .rt_sel    (rt_sel),
  .rt_wr     (rt_wr),
  .rt_oe     (rt_oe),
  .rt_busy   (rt_busy),
  .lt_irq_n  (lt_irq_n),
  .rt_irq_n  (rt_irq_n)
);

// File: tb/mbx_irq_flags_tb.sv
module mbx_irq_flags_tb_top;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - {{(AW-1){1'b0}}, 1'b1};

  logic clk;
  logic rst_n;
  logic [AW-1:0] lt_addr, rt_addr;
  logic lt_sel, lt_wr, lt_oe, lt_busy;
  logic rt_sel, rt_wr, rt_oe, rt_busy;
  logic lt_irq_n, rt_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mbx_irq_flags #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lt_addr(lt_addr), .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_oe(lt_oe), .lt_busy(lt_busy),
    .rt_addr(rt_addr), .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_oe(rt_oe), .rt_busy(rt_busy),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    lt_addr = '0; lt_sel = 0; lt_wr = 0; lt_oe = 0; lt_busy = 0;
    rt_addr = '0; rt_sel = 0; rt_wr = 0; rt_oe = 0; rt_busy = 0;
  endtask

  // one cycle of access on both ports; returns just after the loading edge
  task automatic cyc(input logic [AW-1:0] la, input logic ls, lw, lo, lb,
                     input logic [AW-1:0] ra, input logic rs, rw, ro, rb);
    @(negedge clk);
    lt_addr = la; lt_sel = ls; lt_wr = lw; lt_oe = lo; lt_busy = lb;
    rt_addr = ra; rt_sel = rs; rt_wr = rw; rt_oe = ro; rt_busy = rb;
    @(negedge clk);
    idle();
  endtask

  task automatic lt_acc(input logic [AW-1:0] a, input logic s, w, o, b);
    cyc(a, s, w, o, b, '0, 0, 0, 0, 0);
  endtask

  task automatic rt_acc(input logic [AW-1:0] a, input logic s, w, o, b);
    cyc('0, 0, 0, 0, 0, a, s, w, o, b);
  endtask

  task automatic t_reset();
    chk("R10 lt_irq_n after reset", lt_irq_n, 1'b1);
    chk("R10 rt_irq_n after reset", rt_irq_n, 1'b1);
  endtask

  task automatic t_right_flag();
    lt_acc(TOP, 1, 1, 0, 0);
    chk("R2 R1 rt set by left write to all-ones", rt_irq_n, 1'b0);
    chk("R2 lt untouched", lt_irq_n, 1'b1);
    rt_acc(TOP, 1, 0, 1, 0);
    chk("R4 rt cleared by own read", rt_irq_n, 1'b1);
  endtask

  task automatic t_left_flag();
    rt_acc(NEXT, 1, 1, 0, 0);
    chk("R3 R1 lt set by right write to all-ones minus one", lt_irq_n, 1'b0);
    chk("R3 rt untouched", rt_irq_n, 1'b1);
    lt_acc(NEXT, 1, 0, 1, 0);
    chk("R4 lt cleared by own read", lt_irq_n, 1'b1);
  endtask

  task automatic t_no_oe();
    lt_acc(TOP, 1, 1, 0, 0);
    rt_acc(TOP, 1, 0, 0, 0);
    chk("R5 rt kept without output enable", rt_irq_n, 1'b0);
    rt_acc(TOP, 1, 0, 1, 0);
    chk("R5 cleanup rt", rt_irq_n, 1'b1);
  endtask

  task automatic t_peer_read();
    lt_acc(TOP, 1, 1, 0, 0);
    rt_acc(NEXT, 1, 1, 0, 0);
    lt_acc(TOP, 1, 0, 1, 0);
    chk("R6 rt kept when left reads right mailbox", rt_irq_n, 1'b0);
    rt_acc(NEXT, 1, 0, 1, 0);
    chk("R6 lt kept when right reads left mailbox", lt_irq_n, 1'b0);
    cyc(NEXT, 1, 0, 1, 0, TOP, 1, 0, 1, 0);
    chk("R4 both cleared lt", lt_irq_n, 1'b1);
    chk("R4 both cleared rt", rt_irq_n, 1'b1);
  endtask

  task automatic t_busy_set();
    lt_acc(TOP, 1, 1, 0, 1);
    chk("R7 busy left cannot set rt", rt_irq_n, 1'b1);
    rt_acc(NEXT, 1, 1, 0, 1);
    chk("R7 busy right cannot set lt", lt_irq_n, 1'b1);
  endtask

  task automatic t_busy_clr();
    lt_acc(TOP, 1, 1, 0, 0);
    rt_acc(TOP, 1, 0, 1, 1);
    chk("R8 busy right cannot clear rt", rt_irq_n, 1'b0);
    rt_acc(TOP, 1, 0, 1, 0);
    chk("R8 cleanup rt", rt_irq_n, 1'b1);
  endtask

  task automatic t_set_wins();
    cyc(TOP, 1, 1, 0, 0, TOP, 1, 0, 1, 0);
    chk("R9 set wins over clear on rt", rt_irq_n, 1'b0);
    rt_acc(TOP, 1, 0, 1, 0);
    chk("R9 cleanup rt", rt_irq_n, 1'b1);
  endtask

  task automatic t_other_writes();
    lt_acc(NEXT, 1, 1, 0, 0);
    chk("R11 left write own mailbox lt", lt_irq_n, 1'b1);
    chk("R11 left write own mailbox rt", rt_irq_n, 1'b1);
    lt_acc(TOP, 0, 1, 0, 0);
    chk("R11 unselected write", rt_irq_n, 1'b1);
    lt_acc(NEXT - 1, 1, 1, 0, 0);
    chk("R11 left write other address", rt_irq_n, 1'b1);
    rt_acc(TOP, 1, 1, 0, 0);
    chk("R11 right write own mailbox", lt_irq_n, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_right_flag();
    t_left_flag();
    t_no_oe();
    t_peer_read();
    t_busy_set();
    t_busy_clr();
    t_set_wins();
    t_other_writes();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule